// File: doc/BRIEF.md
# Power-Fail Write Protection Sequencer

This block decides when a battery-backed static memory may be accessed by its host. It watches two comparator flags taken from the supply monitor. One says the supply has sunk below the deselect threshold. The other says it has sunk below the lower threshold at which the memory must run from its battery. Both flags pass through two-flop synchronizers. A four-state controller (normal, protect, battery, recover) then gates the host's select and write strobes toward the memory array. It also commands the output drivers to high impedance, steers memory power to the battery, and raises a ready flag once access is allowed again.

When the supply returns, access is not reopened at once. The sequencer waits a programmable number of clock cycles in a recovery state first. Any new dip during that wait restarts the full delay. If a host write is already under way when protection begins, it may complete for a bounded number of cycles. It ends at once when the host releases its write strobe, or when the switch to battery occurs. A new write is never opened during protection. So only the location under an interrupted write can be damaged.

Top module: `pwr_guard`

## Requirements
- R1: After reset the block sits in the recovery state with `write_protect`=1, `out_hiz`=1, `ready`=0 and `bat_sel`=0. With both flags low, `ready` goes to 1 after RECOVER_CYCLES clock cycles.
- R2: While `ready`=1, `mem_sel` equals `host_sel`, `mem_we` equals `host_sel && host_we`, `write_protect`=0, and `out_hiz` equals `host_we`, so drivers are off during writes.
- R3: A rise of `pf_raw` held steady shows on `write_protect` at the third rising clock edge after it is applied. That is two synchronizer stages plus the state register.
- R4: Outside the normal state, `write_protect`=1 and `out_hiz`=1, and a select or write that was not already running at entry gives `mem_sel`=0 and `mem_we`=0.
- R5: A write active (`host_sel`=1 and `host_we`=1) on the cycle protection starts keeps `mem_we`=1 for at most GRACE_CYCLES cycles. It stops as soon as the host drops the write, and it does not resume after that even if the host writes again.
- R6: A synchronized `so_raw`=1 selects the battery state (`bat_sel`=1) from any state. It ends any ongoing grace write on that same edge.
- R7: When `so_raw` clears while `pf_raw` is still set, `bat_sel` returns to 0 and protection stays on.
- R8: After `pf_raw` clears, `ready` returns to 1 at the eleventh edge for RECOVER_CYCLES=8. In general that is 3 + RECOVER_CYCLES edges.
- R9: A reassertion of `pf_raw` during recovery, even for a single cycle, returns the block to protection. The full recovery delay then restarts after it clears.
- R10: The flag combination `so_raw`=1 with `pf_raw`=0 is treated as battery operation.
- R11: A single-cycle spike on `pf_raw` during normal operation is enough to deselect the memory and start a full recovery.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_raw | input | 1 | Supply below deselect threshold (asynchronous) |
| so_raw | input | 1 | Supply below battery switchover threshold (asynchronous) |
| host_sel | input | 1 | Host chip select request |
| host_we | input | 1 | Host write strobe |
| mem_sel | output | 1 | Gated select toward the memory array |
| mem_we | output | 1 | Gated write strobe toward the memory array |
| write_protect | output | 1 | Host access blocked |
| out_hiz | output | 1 | Memory data drivers to high impedance |
| bat_sel | output | 1 | Memory powered from battery |
| ready | output | 1 | Normal access allowed |

## Verification
The hardest case to reach from the ports is a grace write that is cut short by the switch to battery. It needs a write already running when the synchronized deselect flag lands. Then the switchover flag must reach the controller while the grace window is still open. The stimulus holds a host write and raises the deselect flag. One cycle after protection begins, it raises the switchover flag. It then counts the protected cycles in which the write strobe still reached the memory, and compares that count with both the plain window and the host-release case. A behavioural reference model follows every cycle. This covers recovery restarts and single-cycle spikes.

// File: rtl/pwr_guard.sv
module pwr_guard #(
  parameter int RECOVER_CYCLES = 256,
  parameter int GRACE_CYCLES   = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_raw,
  input  logic so_raw,
  input  logic host_sel,
  input  logic host_we,
  output logic mem_sel,
  output logic mem_we,
  output logic write_protect,
  output logic out_hiz,
  output logic bat_sel,
  output logic ready
);
  localparam int RW = $clog2(RECOVER_CYCLES + 1);
  localparam int GW = $clog2(GRACE_CYCLES + 1);

  typedef enum logic [1:0] {ST_NORMAL, ST_PROTECT, ST_BATTERY, ST_RECOVER} st_t;

  logic [SYNC_STAGES-1:0] pf_q, so_q;
  logic pf_s, so_s;
  st_t st, nxt;
  logic [RW-1:0] rcnt;
  logic [GW-1:0] gcnt;
  logic grace;
  logic wr_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pf_q <= '0;
      so_q <= '0;
    end else begin
      pf_q <= {pf_q[SYNC_STAGES-2:0], pf_raw};
      so_q <= {so_q[SYNC_STAGES-2:0], so_raw};
    end

  assign pf_s   = pf_q[SYNC_STAGES-1];
  assign so_s   = so_q[SYNC_STAGES-1];
  assign wr_act = host_sel && host_we;

  always_comb begin
    nxt = st;
    if (so_s) nxt = ST_BATTERY;
    else begin
      case (st)
        ST_NORMAL:  if (pf_s) nxt = ST_PROTECT;
        ST_PROTECT: if (!pf_s) nxt = ST_RECOVER;
        ST_BATTERY: nxt = pf_s ? ST_PROTECT : ST_RECOVER;
        ST_RECOVER: begin
          if (pf_s) nxt = ST_PROTECT;
          else if (rcnt == RW'(RECOVER_CYCLES - 1)) nxt = ST_NORMAL;
        end
        default:    nxt = ST_PROTECT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= ST_RECOVER;
      rcnt <= '0;
    end else begin
      st   <= nxt;
      rcnt <= (st == ST_RECOVER && nxt == ST_RECOVER) ? rcnt + 1'b1 : '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grace <= 1'b0;
      gcnt  <= '0;
    end else if (st == ST_NORMAL && nxt == ST_PROTECT && wr_act) begin
      grace <= 1'b1;
      gcnt  <= '0;
    end else if (grace && (!wr_act || so_s || gcnt == GW'(GRACE_CYCLES - 1))) begin
      grace <= 1'b0;
    end else if (grace) begin
      gcnt  <= gcnt + 1'b1;
    end

  assign ready         = (st == ST_NORMAL);
  assign write_protect = !ready;
  assign out_hiz       = !ready || host_we;
  assign bat_sel       = (st == ST_BATTERY);
  assign mem_sel       = host_sel && (ready || (grace && host_we));
  assign mem_we        = wr_act && (ready || grace);
endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic host_sel,
  input logic host_we,
  input logic mem_sel,
  input logic mem_we,
  input logic write_protect,
  input logic out_hiz,
  input logic bat_sel,
  input logic ready
);
  assert_normal_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_we == (host_sel && host_we)) && (mem_sel == host_sel));

  assert_protect_drivers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    write_protect |-> out_hiz);

  assert_no_new_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && mem_we) |-> $past(mem_we));

  assert_battery_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> (!mem_we && !mem_sel && write_protect));

  assert_ready_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !bat_sel && $past(!bat_sel));
endmodule

bind pwr_guard pwr_guard_chk u_chk (.*);

// File: tb/pwr_guard_bench.sv
module pwr_guard_bench;
  localparam int REC = 8;
  localparam int GR  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_raw = 1'b0, so_raw = 1'b0, host_sel = 1'b0, host_we = 1'b0;
  logic mem_sel, mem_we, write_protect, out_hiz, bat_sel, ready;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_p1, m_p2, m_s1, m_s2, m_st, m_rc, m_g, m_gc;

  always #2 clk = ~clk;

  pwr_guard #(.RECOVER_CYCLES(REC), .GRACE_CYCLES(GR)) u_pwr_guard (
    .clk(clk), .rst_n(rst_n), .pf_raw(pf_raw), .so_raw(so_raw),
    .host_sel(host_sel), .host_we(host_we), .mem_sel(mem_sel), .mem_we(mem_we),
    .write_protect(write_protect), .out_hiz(out_hiz), .bat_sel(bat_sel), .ready(ready));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_tick(input logic sel, input logic we);
    int nst = m_st;
    bit wa = sel && we;
    if (m_s2 != 0) nst = 2;
    else case (m_st)
      0: if (m_p2 != 0) nst = 1;
      1: if (m_p2 == 0) nst = 3;
      2: nst = (m_p2 != 0) ? 1 : 3;
      default: if (m_p2 != 0) nst = 1; else if (m_rc == REC - 1) nst = 0;
    endcase
    if (m_st == 0 && nst == 1 && wa) begin m_g = 1; m_gc = 0; end
    else if (m_g != 0 && (!wa || m_s2 != 0 || m_gc == GR - 1)) m_g = 0;
    else if (m_g != 0) m_gc++;
    m_rc = (m_st == 3 && nst == 3) ? m_rc + 1 : 0;
    m_p2 = m_p1; m_p1 = pf_raw;
    m_s2 = m_s1; m_s1 = so_raw;
    m_st = nst;
  endtask

  task automatic compare();
    bit rdy = (m_st == 0);
    chk("R8 ready", ready, rdy);
    chk("R4 write_protect", write_protect, !rdy);
    chk("R2 out_hiz", out_hiz, !rdy || host_we);
    chk("R6 bat_sel", bat_sel, m_st == 2);
    chk("R4 mem_sel", mem_sel, host_sel && (rdy || (m_g != 0 && host_we)));
    chk("R5 mem_we", mem_we, host_sel && host_we && (rdy || m_g != 0));
  endtask

  task automatic step(input logic pf, input logic so, input logic sel, input logic we);
    pf_raw = pf; so_raw = so; host_sel = sel; host_we = we;
    @(posedge clk);
    model_tick(sel, we);
    @(negedge clk);
    compare();
  endtask

  initial begin
    int n;
    m_p1 = 0; m_p2 = 0; m_s1 = 0; m_s2 = 0; m_st = 3; m_rc = 0; m_g = 0; m_gc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 reset ready", ready, 1'b0);
    chk("R1 reset protect", write_protect, 1'b1);
    chk("R1 reset hiz", out_hiz, 1'b1);
    chk("R1 reset battery", bat_sel, 1'b0);
    repeat (REC) step(0, 0, 0, 0);
    chk("R1 ready after delay", ready, 1'b1);

    // R2 normal access patterns
    step(0, 0, 1, 0); step(0, 0, 1, 1); step(0, 0, 0, 1); step(0, 0, 1, 1); step(0, 0, 0, 0);
    chk("R2 read passes", mem_sel, 1'b0);

    // R3 deselect latency, R4 ignored access
    step(1, 0, 0, 0); chk("R3 edge1", write_protect, 1'b0);
    step(1, 0, 0, 0); chk("R3 edge2", write_protect, 1'b0);
    step(1, 0, 0, 0); chk("R3 edge3", write_protect, 1'b1);
    step(1, 0, 1, 1); chk("R4 new write blocked", mem_we, 1'b0);
    step(1, 0, 1, 0); chk("R4 read blocked", mem_sel, 1'b0);

    // R8 recovery delay
    n = 0;
    for (int i = 0; i < 40 && !ready; i++) begin step(0, 0, 0, 0); n++; end
    chk("R8 recovery takes 11 edges", n == 11, 1'b1);

    // R5 grace write bounded by GRACE
    n = 0;
    for (int i = 0; i < 10; i++) begin step(1, 0, 1, 1); if (mem_we && !ready) n++; end
    chk("R5 grace length", n == GR, 1'b1);
    repeat (12) step(0, 0, 0, 0);
    chk("R5 back to normal", ready, 1'b1);

    // R5 early release, no re-arm
    n = 0;
    for (int i = 0; i < 4; i++) begin step(1, 0, 1, 1); if (mem_we && !ready) n++; end
    step(1, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin step(1, 0, 1, 1); if (mem_we && !ready) n++; end
    chk("R5 released write not resumed", n == 2, 1'b1);
    repeat (12) step(0, 0, 0, 0);

    // R6 battery cuts grace write
    n = 0;
    for (int i = 0; i < 3; i++) begin step(1, 0, 1, 1); if (mem_we && !ready) n++; end
    for (int i = 0; i < 6; i++) begin step(1, 1, 1, 1); if (mem_we && !ready) n++; end
    chk("R6 grace cut by battery", n == 3, 1'b1);
    chk("R6 battery selected", bat_sel, 1'b1);

    // R7 switchover clears, deselect stays
    repeat (3) step(1, 0, 0, 0);
    chk("R7 battery released", bat_sel, 1'b0);
    chk("R7 still protected", write_protect, 1'b1);

    // R9 reassertion during recovery restarts delay
    repeat (6) step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    n = 0;
    for (int i = 0; i < 40 && !ready; i++) begin step(0, 0, 0, 0); n++; end
    chk("R9 restart delay", n >= REC + 3, 1'b1);

    // R10 illegal combination -> battery
    repeat (3) step(0, 1, 1, 1);
    chk("R10 so without pf is battery", bat_sel, 1'b1);
    repeat (14) step(0, 0, 0, 0);
    chk("R10 recovered", ready, 1'b1);

    // R11 single-cycle spike
    step(1, 0, 0, 0);
    n = 0;
    for (int i = 0; i < 40; i++) begin step(0, 0, 0, 0); if (!ready) n++; end
    chk("R11 spike protects for full delay", n == REC + 1, 1'b1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule